// File: doc/BRIEF.md
# Processor Status Flags Register

This block keeps the condition flags of an 8-bit accumulator-style CPU core: carry, zero, interrupt-disable, decimal, overflow and negative. The ALU and the flag set/clear instructions change any subset of them through a value vector and a matching write mask. The stack-pull path reloads them from a byte read off the stack. The live flag values go out to the rest of the core.

When the core pushes status to the stack, the block forms the byte to write. The stored flags occupy their fixed bit positions. The two upper-middle positions are made up from the push source alone. Bit 5 is always 1. Bit 4 is 1 for a register push or a software break, and 0 for a maskable or non-maskable interrupt. Neither position has a flip-flop behind it, so nothing in the history of the core can reach them.

When a break or an interrupt begins, the interrupt-disable flag is set on the clock edge that ends the push cycle. The pushed byte therefore carries the old value. The decimal flag is stored and pushed like every other flag. Its arithmetic meaning belongs to the ALU, which ignores it here.

Top module: `cpu_status_flags`

## Requirements
- R1: During and after a synchronous active-low reset, `status_view` reads 0x04: only interrupt-disable is set.
- R2: Bits 5 and 4 of `status_view` always read 0, because no storage exists for them.
- R3: The flag vectors are ordered index 0 C, 1 Z, 2 I, 3 D, 4 V, 5 N. On a clock edge without a pull-load, each flag whose `wr_mask` bit is 1 takes the matching `wr_val` bit. Every flag whose mask bit is 0 keeps its value.
- R4: The decimal flag (index 3, byte bit 3) is written, held, pulled and pushed exactly like the other flags.
- R5: Bit 5 of `push_byte` is always 1.
- R6: Bit 4 of `push_byte` is 1 when `push_src` is 2'b00 (register push) or 2'b01 (software break). It is 0 when `push_src` is 2'b10 (maskable interrupt) or 2'b11 (non-maskable interrupt).
- R7: Bits 0-3 and 6-7 of `push_byte` equal the currently stored C, Z, I, D, V and N flags, in that bit order.
- R8: Bits 5 and 4 of `push_byte` depend on nothing but `push_src`. A pull of 0x00 or 0xFF beforehand does not change them.
- R9: When `pull_load` is 1, the next stored flags come from `pull_byte` bits 0-3 and 6-7. Bits 5 and 4 of `pull_byte` are discarded.
- R10: When `pull_load` and a nonzero `wr_mask` occur in the same cycle, the pulled byte alone sets the flags.
- R11: When `push_req` is 1 with a break or interrupt source, I is 1 after that edge, while `push_byte` in that cycle still shows the old I. A register push (`push_src` 2'b00) leaves I unchanged.
- R12: When an interrupt entry and an ALU write that clears I coincide, I ends at 1. A simultaneous pull-load overrides the entry.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_val | input | 6 | Flag values from ALU or set/clear instruction (C,Z,I,D,V,N) |
| wr_mask | input | 6 | Per-flag write enable for `wr_val` |
| pull_load | input | 1 | Load flags from `pull_byte` this cycle |
| pull_byte | input | 8 | Status byte read off the stack |
| push_req | input | 1 | A status push happens this cycle |
| push_src | input | 2 | Push cause: 00 register push, 01 break, 10 IRQ, 11 NMI |
| push_byte | output | 8 | Status byte to write to the stack |
| flags | output | 6 | Live stored flags (C,Z,I,D,V,N) |
| status_view | output | 8 | Stored flags in byte layout, bits 5 and 4 zero |

## Verification
The checker tests the following on every cycle:
- the constant and source-derived push bits;
- the mapping of flags into the pushed byte and the view byte;
- that unmasked flags hold;
- that a pull-load copies the pulled byte;
- that an entry leaves I set.

Some behaviour can only be shown by the bench's scenarios, which compare every cycle with a reference model:
- the push bits staying fixed after pulls of all-zero and all-one bytes;
- the pushed byte showing the old I in the entry cycle;
- the priority among a pull-load, an entry and an ALU write that land in the same cycle.

// File: rtl/psr_pkg.sv
// Package: shared constants and types of the status flags register.
// Assumes the six stored flags are indexed C,Z,I,D,V,N = 0..5.
package psr_pkg;
    localparam int NFLAG  = 6;
    localparam int BYTE_W = 8;
    localparam int IDX_C  = 0;
    localparam int IDX_Z  = 1;
    localparam int IDX_I  = 2;
    localparam int IDX_D  = 3;
    localparam int IDX_V  = 4;
    localparam int IDX_N  = 5;
    localparam int POS_BRK   = 4;
    localparam int POS_ONE   = 5;
    localparam int LOW_FLAGS = 4;  // flags 0..3 sit at byte bits 0..3

    typedef enum logic [1:0] {
        SRC_PHP = 2'b00,
        SRC_BRK = 2'b01,
        SRC_IRQ = 2'b10,
        SRC_NMI = 2'b11
    } push_src_e;

    // Byte bit position of flag index i.
    function automatic int flag_pos(input int i);
        return (i < LOW_FLAGS) ? i : i + 2;
    endfunction
endpackage

// File: rtl/psr_update_mux.sv
// Module: computes the next flag vector. The pull-load has the highest priority.
// Below it, the masked ALU write is applied and an exception entry then forces I.
// Assumes the inputs are stable before the clock edge; purely combinational.
module psr_update_mux
    import psr_pkg::*;
(
    input  logic [NFLAG-1:0] cur,
    input  logic [NFLAG-1:0] wr_val,
    input  logic [NFLAG-1:0] wr_mask,
    input  logic [NFLAG-1:0] pulled,
    input  logic             pull_load,
    input  logic             entry,
    output logic [NFLAG-1:0] nxt
);
    for (genvar i = 0; i < NFLAG; i++) begin : g_bit
        logic after_alu;
        logic after_entry;
        // Per-flag selection: mask write, then entry force on I, then pull override.
        always_comb begin
            after_alu   = wr_mask[i] ? wr_val[i] : cur[i];
            after_entry = (i == IDX_I) ? (after_alu | entry) : after_alu;
            nxt[i]      = pull_load ? pulled[i] : after_entry;
        end
    end
endmodule

// File: rtl/psr_flag_store.sv
// Module: the six flip-flops of stored flags, with synchronous active-low reset.
// Assumes RESET_FLAGS is given in flag-index order.
module psr_flag_store
    import psr_pkg::*;
#(
    parameter logic [NFLAG-1:0] RESET_FLAGS = 6'b000100
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NFLAG-1:0] d,
    output logic [NFLAG-1:0] q
);
    for (genvar i = 0; i < NFLAG; i++) begin : g_ff
        // One flag bit: load the reset value or the next value.
        always_ff @(posedge clk) begin
            if (!rst_n) q[i] <= RESET_FLAGS[i];
            else        q[i] <= d[i];
        end
    end
endmodule

// File: rtl/psr_push_former.sv
// Module: builds the byte written to the stack on a status push.
// Bit 5 is a constant 1. Bit 4 comes only from the push source. The rest are stored flags.
module psr_push_former
    import psr_pkg::*;
(
    input  logic [NFLAG-1:0]  cur,
    input  push_src_e         src,
    output logic [BYTE_W-1:0] push_byte
);
    // Assemble the pushed byte from the flags and the source.
    always_comb begin
        push_byte = '0;
        for (int i = 0; i < NFLAG; i++) push_byte[flag_pos(i)] = cur[i];
        push_byte[POS_ONE] = 1'b1;
        push_byte[POS_BRK] = (src == SRC_PHP) || (src == SRC_BRK);
    end
endmodule

// File: rtl/cpu_status_flags.sv
// Module: top of the processor status flags register.
// Holds C,Z,I,D,V,N, applies ALU and pull updates, and forms the pushed status byte.
// Assumes the decoder asserts push_req only in the cycle the status byte is written.
module cpu_status_flags
    import psr_pkg::*;
#(
    parameter logic [7:0] RESET_STATUS = 8'h04
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [5:0]  wr_val,
    input  logic [5:0]  wr_mask,
    input  logic        pull_load,
    input  logic [7:0]  pull_byte,
    input  logic        push_req,
    input  logic [1:0]  push_src,
    output logic [7:0]  push_byte,
    output logic [5:0]  flags,
    output logic [7:0]  status_view
);
    localparam logic [NFLAG-1:0] RESET_FLAGS =
        {RESET_STATUS[7:6], RESET_STATUS[3:0]};

    logic [NFLAG-1:0] pulled;
    logic [NFLAG-1:0] nxt;
    logic             entry;
    logic [1:0]       discard_unused;
    push_src_e        src;

    // Decode the push cause; any push other than a register push is an exception entry.
    always_comb begin
        src            = push_src_e'(push_src);
        entry          = push_req && (src != SRC_PHP);
        discard_unused = pull_byte[POS_ONE:POS_BRK];
    end

    for (genvar i = 0; i < NFLAG; i++) begin : g_map
        // Gather the pulled flags and spread the stored flags into the view byte.
        assign pulled[i]               = pull_byte[flag_pos(i)];
        assign status_view[flag_pos(i)] = flags[i];
    end
    assign status_view[POS_ONE:POS_BRK] = 2'b00;

    psr_update_mux u_mux (
        .cur       (flags),
        .wr_val    (wr_val),
        .wr_mask   (wr_mask),
        .pulled    (pulled),
        .pull_load (pull_load),
        .entry     (entry),
        .nxt       (nxt)
    );

    psr_flag_store #(.RESET_FLAGS(RESET_FLAGS)) u_store (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (nxt),
        .q     (flags)
    );

    psr_push_former u_push (
        .cur       (flags),
        .src       (src),
        .push_byte (push_byte)
    );
endmodule

// File: rtl/psr_checker.sv
// Module: assertion checker for cpu_status_flags, attached by bind.
module psr_checker #(
    parameter logic [7:0] RESET_STATUS = 8'h04
) (
    input logic       clk,
    input logic       rst_n,
    input logic [5:0] wr_mask,
    input logic       pull_load,
    input logic [7:0] pull_byte,
    input logic       push_req,
    input logic [1:0] push_src,
    input logic [7:0] push_byte,
    input logic [5:0] flags,
    input logic [7:0] status_view
);
    assert_reset_value_R1: assert property (@(posedge clk)
        !rst_n |=> status_view == (RESET_STATUS & 8'hCF));

    assert_no_storage_bits_R2: assert property (@(posedge clk) disable iff (!rst_n)
        status_view[5:4] == 2'b00);

    assert_masked_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!pull_load && !push_req) |=> ((flags ^ $past(flags)) & ~$past(wr_mask)) == 6'd0);

    assert_bit5_one_R5: assert property (@(posedge clk) disable iff (!rst_n)
        push_byte[5] == 1'b1);

    assert_bit4_source_R6: assert property (@(posedge clk) disable iff (!rst_n)
        push_byte[4] == !push_src[1]);

    assert_flag_map_R7: assert property (@(posedge clk) disable iff (!rst_n)
        {push_byte[7:6], push_byte[3:0]} == flags);

    assert_pull_copy_R9: assert property (@(posedge clk) disable iff (!rst_n)
        pull_load |=> flags == {$past(pull_byte[7:6]), $past(pull_byte[3:0])});

    assert_entry_sets_i_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (push_req && push_src != 2'b00 && !pull_load) |=> flags[2]);
endmodule

bind cpu_status_flags psr_checker #(.RESET_STATUS(RESET_STATUS)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .wr_mask     (wr_mask),
    .pull_load   (pull_load),
    .pull_byte   (pull_byte),
    .push_req    (push_req),
    .push_src    (push_src),
    .push_byte   (push_byte),
    .flags       (flags),
    .status_view (status_view)
);

// File: tb/sim_cpu_status_flags.sv
`timescale 1ns/1ps
module sim_cpu_status_flags;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [5:0] wr_val = '0;
    logic [5:0] wr_mask = '0;
    logic       pull_load = 1'b0;
    logic [7:0] pull_byte = '0;
    logic       push_req = 1'b0;
    logic [1:0] push_src = '0;
    logic [7:0] push_byte;
    logic [5:0] flags;
    logic [7:0] status_view;

    int checks = 0;
    int errors = 0;
    logic [5:0] model = 6'b000100;

    always #2.5 clk = ~clk;

    cpu_status_flags u0 (
        .clk(clk), .rst_n(rst_n), .wr_val(wr_val), .wr_mask(wr_mask),
        .pull_load(pull_load), .pull_byte(pull_byte), .push_req(push_req),
        .push_src(push_src), .push_byte(push_byte), .flags(flags),
        .status_view(status_view)
    );

    function automatic logic [7:0] view_of(input logic [5:0] f);
        return {f[5:4], 2'b00, f[3:0]};
    endfunction

    function automatic logic [7:0] push_of(input logic [5:0] f, input logic [1:0] s);
        return {f[5:4], 1'b1, (s == 2'b00 || s == 2'b01), f[3:0]};
    endfunction

    function automatic logic [5:0] next_of(input logic [5:0] f, input logic [5:0] v,
                                           input logic [5:0] m, input logic pl,
                                           input logic [7:0] pb, input logic pr,
                                           input logic [1:0] s);
        logic [5:0] n;
        if (pl) return {pb[7:6], pb[3:0]};
        n = (f & ~m) | (v & m);
        if (pr && s != 2'b00) n[2] = 1'b1;
        return n;
    endfunction

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    // One cycle: drive at the falling edge, check the push byte, clock, then check the state.
    task automatic cycle(input string req, input logic [5:0] v, input logic [5:0] m,
                         input logic pl, input logic [7:0] pb, input logic pr,
                         input logic [1:0] s);
        @(negedge clk);
        wr_val = v; wr_mask = m; pull_load = pl; pull_byte = pb;
        push_req = pr; push_src = s;
        #1;
        chk({req, " push"}, push_byte, push_of(model, s));
        model = next_of(model, v, m, pl, pb, pr, s);
        @(posedge clk);
        #1;
        chk({req, " state"}, status_view, view_of(model));
    endtask

    initial begin
        #(200000 * 5);
        errors++; checks++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        repeat (3) @(posedge clk);
        #1;
        chk("R1 reset view", status_view, 8'h04);
        @(negedge clk); rst_n = 1'b1;
        #1;
        chk("R1 after release", status_view, 8'h04);

        // R3: set C and V only, the others hold
        cycle("R3", 6'b111111, 6'b010001, 1'b0, 8'h00, 1'b0, 2'b00);
        // R4: decimal written, held and pushed (R7 by php push)
        cycle("R4 write", 6'b001000, 6'b001000, 1'b0, 8'h00, 1'b0, 2'b00);
        cycle("R4 push", 6'b000000, 6'b000000, 1'b0, 8'h00, 1'b1, 2'b00);
        chk("R4 D held", {7'd0, flags[3]}, 8'h01);
        // R9 / R8: pull all ones, then push from every source
        cycle("R9 pull FF", 6'b000000, 6'b000000, 1'b1, 8'hFF, 1'b0, 2'b00);
        chk("R2 view after FF", status_view, 8'hCF);
        cycle("R8 php after FF", 6'b000000, 6'b000000, 1'b0, 8'h00, 1'b1, 2'b00);
        chk("R6 irq byte after FF", push_of(model, 2'b10), 8'hEF);
        cycle("R8 irq after FF", 6'b000000, 6'b000000, 1'b0, 8'h00, 1'b1, 2'b10);
        // Pull zeros: bits 5/4 of push unaffected
        cycle("R9 pull 00", 6'b000000, 6'b000000, 1'b1, 8'h00, 1'b0, 2'b00);
        @(negedge clk); push_src = 2'b01; #1;
        chk("R8 brk after 00", push_byte, 8'h30);
        push_src = 2'b11; #1;
        chk("R6 nmi after 00", push_byte, 8'h20);
        // R11: entry pushes old I=0 then sets I; php leaves I
        cycle("R11 php keeps I", 6'b000000, 6'b000000, 1'b0, 8'h00, 1'b1, 2'b00);
        chk("R11 I still 0", {7'd0, flags[2]}, 8'h00);
        cycle("R11 nmi entry", 6'b000000, 6'b000000, 1'b0, 8'h00, 1'b1, 2'b11);
        chk("R11 I set", {7'd0, flags[2]}, 8'h01);
        // R10: pull wins over ALU
        cycle("R10 pull vs alu", 6'b111111, 6'b111111, 1'b1, 8'h42, 1'b0, 2'b00);
        chk("R10 view", status_view, 8'h42);
        // R12: entry beats ALU clear of I; pull beats entry
        cycle("R12 entry vs alu", 6'b000000, 6'b000100, 1'b0, 8'h00, 1'b1, 2'b10);
        chk("R12 I wins", {7'd0, flags[2]}, 8'h01);
        cycle("R12 pull vs entry", 6'b000000, 6'b000000, 1'b1, 8'h00, 1'b1, 2'b01);
        chk("R12 pull wins", status_view, 8'h00);

        // Random mix (R3, R5, R6, R7, R9)
        for (int k = 0; k < 400; k++) begin
            cycle("R3/R7 random", 6'($urandom), 6'($urandom),
                  ($urandom % 8) == 0, 8'($urandom),
                  ($urandom % 4) == 0, 2'($urandom));
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule